// File: doc/BRIEF.md
# Replica Writeback Router

When an L1 cache evicts a block, this router picks one of two destinations. The first is the core's own private L2 slice, where the block may become an extra copy. The second is the next slice clockwise on a ring of slices, where the block travels until it meets and merges with a copy that is already there. Only a block that more than one core has requested, and that nobody has written, may take the local path. A random draw decides each such block. The draw's probability comes from an adaptive replication level between 0 and 5 that an outside controller sets.

A request carries its address, its dirty and shared status bits and the current level, and enters through a valid/ready handshake. One cycle after a request is accepted, the router either pulses a local-write strobe with the address, or raises a ring message that carries the address and the index of the neighbouring slice. The ring output holds until the ring side accepts it, and while it holds, new requests are stalled. The random bits come from an input port by default. A parameter can replace them with an internal LFSR.

Top module: `wbr_router`

## Requirements
- R1: After reset, `loc_wr` and `ring_valid` are low and `req_ready` is high.
- R2: A request with `req_dirty` = 1 always takes the ring path, whatever its other inputs.
- R3: A request with `req_shared` = 0 always takes the ring path, whatever its other inputs.
- R4: An eligible request (`req_shared` = 1, `req_dirty` = 0) takes the local path exactly when the 3-bit random value `rnd_bits`, read as unsigned, is below the threshold floor(8*L/5). Here L is `repl_level`, and a level of 6 or 7 is treated as 5. For levels 0 to 5 the thresholds are 0, 1, 3, 4, 6 and 8.
- R5: At level 0, no request ever takes the local path. At level 5, every eligible request takes the local path.
- R6: `ring_dest` equals (`own_id` + 1) mod 8 whenever `ring_valid` is high.
- R7: The result appears in the cycle after the clock edge that accepts the request (`req_valid` and `req_ready` both high). It carries the request's address on `loc_addr` or `ring_addr`.
- R8: While `ring_valid` is high and `ring_ready` is low, `ring_valid`, `ring_addr` and `ring_dest` hold their values and `req_ready` is low. When `ring_ready` rises, a waiting request is accepted on that same edge.
- R9: Each accepted request produces exactly one result: either a one-cycle `loc_wr` pulse or a new ring message, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_id | input | 3 | Index of this core's slice on the ring |
| repl_level | input | 3 | Replication level, 0 to 5 (6 and 7 clamp to 5) |
| rnd_bits | input | 3 | External random value for the draw |
| req_valid | input | 1 | Writeback request valid |
| req_ready | output | 1 | Router can take a request |
| req_addr | input | 32 | Block address of the writeback |
| req_dirty | input | 1 | Block has been written |
| req_shared | input | 1 | Block has had more than one requester |
| loc_wr | output | 1 | One-cycle strobe: write the block into the local slice |
| loc_addr | output | 32 | Address for the local write |
| ring_valid | output | 1 | Ring message valid |
| ring_ready | input | 1 | Ring accepts the message |
| ring_addr | output | 32 | Address carried on the ring |
| ring_dest | output | 3 | Index of the next slice clockwise |

## Verification
The bench sweeps every combination of level (including the clamped levels 6 and 7), random value, dirty bit and shared bit. This exposes a threshold that is off by one, which would replicate at level 0 or refuse to at level 5. It also exposes an eligibility test that lets dirty or private blocks replicate. A sweep over all slice indices catches a destination that fails to wrap from the last slice to slice 0. A stalled ring message is then held for several cycles while a second request waits: a design that let the payload change, or that accepted the new request early, would lose a writeback.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

   // Highest meaningful replication level; anything above clamps here.
   localparam int unsigned MAX_LEVEL = 5;

   typedef enum logic {
      ROUTE_RING  = 1'b0,
      ROUTE_LOCAL = 1'b1
   } route_e;

   // Threshold for a given (already clamped) level over a RW-bit draw space.
   function automatic int unsigned level_threshold(input int unsigned lvl,
                                                   input int unsigned rw);
      return (lvl * (1 << rw)) / MAX_LEVEL;
   endfunction

endpackage

// File: rtl/wbr_lfsr.sv
module wbr_lfsr #(
   parameter int unsigned LW    = 16,
   parameter int unsigned OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   initial begin
      assert (LW == 16) else $error("wbr_lfsr: only a 16-bit polynomial is provided");
      assert (OUT_W <= LW) else $error("wbr_lfsr: output wider than state");
   end

   logic [LW-1:0] state_q;
   logic          fb;

   assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= {{(LW-1){1'b0}}, 1'b1};
      else        state_q <= {state_q[LW-2:0], fb};
   end

   assign rnd = state_q[OUT_W-1:0];

   p_lfsr_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
endmodule

// File: rtl/wbr_threshold.sv
module wbr_threshold #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned RND_W = 3,
   localparam int unsigned THR_W = RND_W + 1
) (
   input  logic [LVL_W-1:0] level,
   output logic [THR_W-1:0] thr
);
   import wbr_pkg::*;

   localparam int unsigned N_LVL = 1 << LVL_W;

   initial begin
      assert (N_LVL > MAX_LEVEL) else $error("wbr_threshold: level field too narrow");
   end

   logic [THR_W-1:0] table_w [N_LVL];

   for (genvar g = 0; g < N_LVL; g++) begin : g_tab
      localparam int unsigned CL = (g > MAX_LEVEL) ? MAX_LEVEL : g;
      assign table_w[g] = THR_W'(level_threshold(CL, RND_W));
   end

   assign thr = table_w[level];
endmodule

// File: rtl/wbr_route_decide.sv
module wbr_route_decide #(
   parameter int unsigned RND_W = 3,
   localparam int unsigned THR_W = RND_W + 1
) (
   input  logic             dirty,
   input  logic             shared,
   input  logic [RND_W-1:0] rnd,
   input  logic [THR_W-1:0] thr,
   output wbr_pkg::route_e  route
);
   import wbr_pkg::*;

   logic eligible;
   logic draw_hit;

   assign eligible = shared & ~dirty;
   assign draw_hit = ({1'b0, rnd} < thr);

   always_comb begin
      route = ROUTE_RING;
      if (eligible && draw_hit) route = ROUTE_LOCAL;
   end

   always_comb begin
      if (dirty) assert (route == ROUTE_RING) else $error("p_dirty_ring_r2");
   end
endmodule

// File: rtl/wbr_out_stage.sv
module wbr_out_stage #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_local,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [IDX_W-1:0]  in_dest,
   output logic              loc_wr,
   output logic [ADDR_W-1:0] loc_addr,
   output logic              ring_valid,
   input  logic              ring_ready,
   output logic [ADDR_W-1:0] ring_addr,
   output logic [IDX_W-1:0]  ring_dest
);
   logic acc;

   assign in_ready = ~ring_valid | ring_ready;
   assign acc      = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_wr     <= 1'b0;
         loc_addr   <= '0;
         ring_valid <= 1'b0;
         ring_addr  <= '0;
         ring_dest  <= '0;
      end else begin
         loc_wr <= acc & in_local;
         if (acc && in_local) loc_addr <= in_addr;
         if (acc && !in_local) begin
            ring_valid <= 1'b1;
            ring_addr  <= in_addr;
            ring_dest  <= in_dest;
         end else if (ring_ready) begin
            ring_valid <= 1'b0;
         end
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_valid && !ring_ready |=> ring_valid && $stable(ring_addr) && $stable(ring_dest));

   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_valid && !ring_ready |-> !in_ready);

   p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> loc_wr || ring_valid);

   p_local_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_local |=> loc_wr && loc_addr == $past(in_addr));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !loc_wr);
endmodule

// File: rtl/wbr_router.sv
module wbr_router #(
   parameter int unsigned N_CORES  = 8,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned RND_W    = 3,
   parameter bit          INT_LFSR = 1'b0,
   localparam int unsigned IDX_W   = $clog2(N_CORES),
   localparam int unsigned THR_W   = RND_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  own_id,
   input  logic [LVL_W-1:0]  repl_level,
   input  logic [RND_W-1:0]  rnd_bits,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_dirty,
   input  logic              req_shared,
   output logic              loc_wr,
   output logic [ADDR_W-1:0] loc_addr,
   output logic              ring_valid,
   input  logic              ring_ready,
   output logic [ADDR_W-1:0] ring_addr,
   output logic [IDX_W-1:0]  ring_dest
);
   import wbr_pkg::*;

   initial begin
      assert (N_CORES >= 2) else $error("wbr_router: ring needs at least two slices");
      assert (RND_W >= 1 && RND_W <= 8) else $error("wbr_router: RND_W out of range");
      assert (ADDR_W >= 1) else $error("wbr_router: ADDR_W must be positive");
   end

   logic [RND_W-1:0] rnd;
   logic [THR_W-1:0] thr;
   route_e           route;
   logic [IDX_W-1:0] next_id;

   if (INT_LFSR) begin : g_lfsr
      wbr_lfsr #(.LW(16), .OUT_W(RND_W)) u_lfsr (
         .clk (clk),
         .rst_n (rst_n),
         .rnd (rnd)
      );
   end else begin : g_ext
      assign rnd = rnd_bits;
   end

   wbr_threshold #(.LVL_W(LVL_W), .RND_W(RND_W)) u_thr (
      .level (repl_level),
      .thr   (thr)
   );

   wbr_route_decide #(.RND_W(RND_W)) u_dec (
      .dirty  (req_dirty),
      .shared (req_shared),
      .rnd    (rnd),
      .thr    (thr),
      .route  (route)
   );

   assign next_id = (own_id == IDX_W'(N_CORES - 1)) ? '0 : own_id + 1'b1;

   wbr_out_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid),
      .in_ready   (req_ready),
      .in_local   (route == ROUTE_LOCAL),
      .in_addr    (req_addr),
      .in_dest    (next_id),
      .loc_wr     (loc_wr),
      .loc_addr   (loc_addr),
      .ring_valid (ring_valid),
      .ring_ready (ring_ready),
      .ring_addr  (ring_addr),
      .ring_dest  (ring_dest)
   );

   p_level0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && repl_level == '0 |=> !loc_wr);

   p_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_dirty |=> !loc_wr && ring_valid);

   p_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_shared |=> !loc_wr && ring_valid);

   p_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !loc_wr |=> !ring_valid || ring_dest != $past(own_id));
endmodule

// File: tb/sim_wbr_router.sv
module sim_wbr_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  own_id = '0;
   logic [2:0]  repl_level = '0;
   logic [2:0]  rnd_bits = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_dirty = 1'b0;
   logic        req_shared = 1'b0;
   logic        loc_wr;
   logic [31:0] loc_addr;
   logic        ring_valid;
   logic        ring_ready = 1'b1;
   logic [31:0] ring_addr;
   logic [2:0]  ring_dest;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   wbr_router u0 (
      .clk (clk), .rst_n (rst_n), .own_id (own_id), .repl_level (repl_level),
      .rnd_bits (rnd_bits), .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_dirty (req_dirty), .req_shared (req_shared),
      .loc_wr (loc_wr), .loc_addr (loc_addr), .ring_valid (ring_valid),
      .ring_ready (ring_ready), .ring_addr (ring_addr), .ring_dest (ring_dest)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One request with ring always ready; checks the result one edge later.
   task automatic send(input int lvl, input int rv, input bit d, input bit s,
                       input int id, input logic [31:0] a, input string req);
      int eff, thr;
      bit exp_local;
      @(negedge clk);
      repl_level = 3'(lvl); rnd_bits = 3'(rv); req_dirty = d; req_shared = s;
      own_id = 3'(id); req_addr = a; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      eff = (lvl > 5) ? 5 : lvl;
      thr = (8 * eff) / 5;
      exp_local = s && !d && (rv < thr);
      check(loc_wr == exp_local, req, "loc_wr", loc_wr, exp_local);
      check(ring_valid == !exp_local, req, "ring_valid", ring_valid, !exp_local);
      if (exp_local)
         check(loc_addr == a, "R7", "loc_addr", loc_addr, a);
      else begin
         check(ring_addr == a, "R7", "ring_addr", ring_addr, a);
         check(ring_dest == 3'((id + 1) % 8), "R6", "ring_dest", ring_dest, (id + 1) % 8);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check(loc_wr == 1'b0, "R1", "loc_wr", loc_wr, 0);
      check(ring_valid == 1'b0, "R1", "ring_valid", ring_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);

      // R2 R3 R4 R5: full sweep of level, draw, dirty, shared
      for (int l = 0; l < 8; l++)
         for (int r = 0; r < 8; r++)
            for (int d = 0; d < 2; d++)
               for (int s = 0; s < 2; s++)
                  send(l, r, d[0], s[0], (l + r) % 8, 32'h1000 + 32'(l*64 + r*4 + d*2 + s),
                       d ? "R2" : (!s ? "R3" : ((l == 0 || l >= 5) ? "R5" : "R4")));

      // R6: destination wrap for every slice index
      for (int id = 0; id < 8; id++)
         send(3, 0, 1'b1, 1'b0, id, 32'hA000 + 32'(id), "R6");

      // R9: a local result is a single-cycle pulse
      send(5, 7, 1'b0, 1'b1, 2, 32'hBEEF, "R9");
      @(negedge clk);
      check(loc_wr == 1'b0, "R9", "loc_wr second cycle", loc_wr, 0);

      // R8: backpressure
      @(negedge clk);
      ring_ready = 1'b0;
      repl_level = 3'd0; req_dirty = 1'b1; req_shared = 1'b0; own_id = 3'd7;
      req_addr = 32'hC0DE_0001; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 32'hC0DE_0002;
      check(ring_valid == 1'b1, "R8", "ring_valid", ring_valid, 1);
      check(req_ready == 1'b0, "R8", "req_ready stalled", req_ready, 0);
      repeat (3) @(negedge clk);
      check(ring_valid == 1'b1, "R8", "ring_valid held", ring_valid, 1);
      check(ring_addr == 32'hC0DE_0001, "R8", "ring_addr held", ring_addr, 32'hC0DE_0001);
      check(ring_dest == 3'd0, "R8", "ring_dest held", ring_dest, 0);
      ring_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(ring_addr == 32'hC0DE_0002, "R8", "next accepted on release", ring_addr, 32'hC0DE_0002);
      check(ring_valid == 1'b1, "R8", "ring_valid second", ring_valid, 1);
      @(negedge clk);
      check(ring_valid == 1'b0, "R8", "ring drained", ring_valid, 0);
      check(loc_wr == 1'b0, "R9", "no local during ring", loc_wr, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule